// File: doc/BRIEF.md
# Indexed and Auto-Increment Address Generator

This block works out the effective addresses of a load/store unit's extended memory operations and the value written back to the base register. Four operation forms are handled. The first is register-plus-scaled-register indexing, where the index can optionally be reduced to its low 32 bits, zero-extended. The second and third are auto-increment with the base update applied before the access and after it. The fourth is paired access, which yields two adjacent addresses in the same cycle. The block also flags register-number combinations that make a load meaningless.

A request is presented with `req_valid` together with the operand values, immediate fields, the operation form and the register numbers. Results appear on registered outputs one clock later. Memory access, alignment handling and the extension of load data are done by the surrounding pipeline.

Top module: `agen_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `wb_en`, `addr1_en` and `illegal` are 0. A request sampled with `req_valid`=1 produces `out_valid`=1 on the next clock. A cycle without a request produces `out_valid`=0 with all three flags at 0.
- R2: With `op_mode`=0 (indexed), `addr0` = `base` + (`index` << `scale`), where `scale` is 2 bits, modulo 2^XLEN.
- R3: In indexed form with `idx_zext`=1, only `index[31:0]` is used, zero-extended, before scaling. With `idx_zext`=0 the full `index` is used.
- R4: The increment offset is `imm5`, read as a signed 5-bit value, sign-extended and shifted left by `scale`.
- R5: With `op_mode`=1 (update before access), `addr0` = `base` + offset, `wb_value` = `base` + offset, and `wb_en`=1.
- R6: With `op_mode`=2 (update after access), `addr0` = `base`, `wb_value` = `base` + offset, and `wb_en`=1.
- R7: An increment-form load (`is_load`=1) whose `rs1` equals `rd` raises `illegal` and forces `wb_en`=0. Increment-form stores with the same register numbers are legal.
- R8: With `op_mode`=3 (pair), `addr0` = `base` + (`sh2` << 4) when `pair_dw`=1, or `base` + (`sh2` << 3) when `pair_dw`=0. `addr1` = `addr0` + 8 or + 4 respectively, and `addr1_en`=1.
- R9: A pair load raises `illegal` and forces `addr1_en`=0 when `rs1` equals `rd` or `rd2`, or when `rd` equals `rd2`. Pair stores are never flagged.
- R10: Indexed and pair operations never assert `wb_en`. Only a legal pair operation asserts `addr1_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| op_mode | input | 2 | 0 indexed, 1 update-before, 2 update-after, 3 pair |
| is_load | input | 1 | 1 for load, 0 for store |
| idx_zext | input | 1 | Indexed form: use zero-extended low 32 bits of index |
| pair_dw | input | 1 | Pair form: 1 for 8-byte elements, 0 for 4-byte |
| base | input | XLEN | Base register value |
| index | input | XLEN | Index register value |
| imm5 | input | 5 | Signed increment immediate |
| scale | input | 2 | Shift amount for index or increment |
| sh2 | input | 2 | Pair offset field |
| rs1 | input | 5 | Base register number |
| rd | input | 5 | Destination/data register number (first of a pair) |
| rd2 | input | 5 | Second pair register number |
| out_valid | output | 1 | Results valid |
| addr0 | output | XLEN | First access address |
| addr1 | output | XLEN | Second access address (pair) |
| addr1_en | output | 1 | Second address in use |
| wb_value | output | XLEN | New base register value |
| wb_en | output | 1 | Base writeback requested |
| illegal | output | 1 | Register combination not allowed |

## Verification
Some rules hold on every cycle and are covered by assertions. These are the one-cycle request-to-result timing, the exclusivity of `wb_en` and `addr1_en`, and the suppression of both by `illegal`. The same applies to the 4- or 8-byte spacing of pair addresses, the equality of `addr0` and `wb_value` in the update-before form, and `addr0` tracking the base in the update-after form. The exact arithmetic only shows up in the bench's vectors. That covers negative and zero-extended indices, negative immediates, the pair offset scaling, the store exemptions from the conflict rules, and reset taken while a request is in flight.

// File: rtl/agen_pkg.sv
// Shared operation-form encoding for the address generator.
package agen_pkg;
    typedef enum logic [1:0] {
        AM_INDEX   = 2'd0,
        AM_PREINC  = 2'd1,
        AM_POSTINC = 2'd2,
        AM_PAIR    = 2'd3
    } agen_mode_e;
endpackage

// File: rtl/agen_index_unit.sv
// Scaled register+register address. Assumes XLEN >= 32; when XLEN is
// exactly 32 the zero-extension choice makes no difference.
module agen_index_unit #(
    parameter int XLEN = 64,
    parameter int SCW  = 2
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] index,
    input  logic [SCW-1:0]  scale,
    input  logic            zext,
    output logic [XLEN-1:0] addr
);
    logic [XLEN-1:0] idx_eff;

    generate
        if (XLEN > 32) begin : g_wide
            // Pick full index or zero-extended low word.
            always_comb idx_eff = zext ? {{(XLEN-32){1'b0}}, index[31:0]} : index;
        end else begin : g_narrow
            // Narrow datapath: the low word is the whole index.
            always_comb idx_eff = index;
        end
    endgenerate

    // Add the scaled index to the base.
    always_comb addr = base + (idx_eff << scale);
endmodule

// File: rtl/agen_incr_unit.sv
// Auto-increment form: signed immediate scaled by a shift, applied either
// before the access (pre) or only to the written-back base (post).
module agen_incr_unit #(
    parameter int XLEN = 64,
    parameter int IMMW = 5,
    parameter int SCW  = 2
) (
    input  logic [XLEN-1:0] base,
    input  logic [IMMW-1:0] imm,
    input  logic [SCW-1:0]  scale,
    input  logic            pre,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] wb
);
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] offset;

    // Sign-extend and scale the immediate.
    always_comb begin
        imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        offset = imm_sx << scale;
    end

    // Updated base; access uses it only in the pre form.
    always_comb begin
        wb   = base + offset;
        addr = pre ? wb : base;
    end
endmodule

// File: rtl/agen_pair_unit.sv
// Paired access: first address is base plus a field scaled by twice the
// element size, second is the next element.
module agen_pair_unit #(
    parameter int XLEN = 64,
    parameter int FW   = 2
) (
    input  logic [XLEN-1:0] base,
    input  logic [FW-1:0]   field,
    input  logic            dword,
    output logic [XLEN-1:0] addr0,
    output logic [XLEN-1:0] addr1
);
    localparam int SH_DW   = 4;
    localparam int SH_W    = 3;
    localparam int ELEM_DW = 8;
    localparam int ELEM_W  = 4;

    logic [XLEN-1:0] field_x;
    logic [XLEN-1:0] step;

    // Widen the offset field and pick element step.
    always_comb begin
        field_x = {{(XLEN-FW){1'b0}}, field};
        step    = dword ? XLEN'(ELEM_DW) : XLEN'(ELEM_W);
    end

    // Form both addresses.
    always_comb begin
        addr0 = base + (dword ? (field_x << SH_DW) : (field_x << SH_W));
        addr1 = addr0 + step;
    end
endmodule

// File: rtl/agen_conflict_chk.sv
// Register-number conflict rules for loads. Stores are never flagged;
// indexed forms have no conflict rule.
module agen_conflict_chk #(
    parameter int REGW = 5
) (
    input  agen_pkg::agen_mode_e mode,
    input  logic                 is_load,
    input  logic [REGW-1:0]      rs1,
    input  logic [REGW-1:0]      rd,
    input  logic [REGW-1:0]      rd2,
    output logic                 bad
);
    import agen_pkg::*;

    // Evaluate the rule that applies to the current form.
    always_comb begin
        unique case (mode)
            AM_PREINC, AM_POSTINC: bad = is_load && (rs1 == rd);
            AM_PAIR:               bad = is_load && ((rs1 == rd) || (rs1 == rd2) || (rd == rd2));
            default:               bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/agen_top.sv
// Address generator top: selects the unit for the requested form, applies
// the conflict rule and registers all results one cycle after the request.
// Assumes a request is a single-cycle pulse with stable operands.
module agen_top #(
    parameter int XLEN = 64,
    parameter int REGW = 5,
    parameter int IMMW = 5,
    parameter int SCW  = 2,
    parameter int FW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      op_mode,
    input  logic            is_load,
    input  logic            idx_zext,
    input  logic            pair_dw,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] index,
    input  logic [IMMW-1:0] imm5,
    input  logic [SCW-1:0]  scale,
    input  logic [FW-1:0]   sh2,
    input  logic [REGW-1:0] rs1,
    input  logic [REGW-1:0] rd,
    input  logic [REGW-1:0] rd2,
    output logic            out_valid,
    output logic [XLEN-1:0] addr0,
    output logic [XLEN-1:0] addr1,
    output logic            addr1_en,
    output logic [XLEN-1:0] wb_value,
    output logic            wb_en,
    output logic            illegal
);
    import agen_pkg::*;

    agen_mode_e      mode;
    logic [XLEN-1:0] idx_addr;
    logic [XLEN-1:0] inc_addr, inc_wb;
    logic [XLEN-1:0] pr_addr0, pr_addr1;
    logic            bad;
    logic [XLEN-1:0] nx_addr0;
    logic            nx_wb_en, nx_a1_en;

    // Give the raw mode field its enumerated type.
    always_comb mode = agen_mode_e'(op_mode);

    agen_index_unit #(.XLEN(XLEN), .SCW(SCW)) u_idx (
        .base(base), .index(index), .scale(scale), .zext(idx_zext), .addr(idx_addr)
    );

    agen_incr_unit #(.XLEN(XLEN), .IMMW(IMMW), .SCW(SCW)) u_inc (
        .base(base), .imm(imm5), .scale(scale), .pre(mode == AM_PREINC),
        .addr(inc_addr), .wb(inc_wb)
    );

    agen_pair_unit #(.XLEN(XLEN), .FW(FW)) u_pair (
        .base(base), .field(sh2), .dword(pair_dw), .addr0(pr_addr0), .addr1(pr_addr1)
    );

    agen_conflict_chk #(.REGW(REGW)) u_chk (
        .mode(mode), .is_load(is_load), .rs1(rs1), .rd(rd), .rd2(rd2), .bad(bad)
    );

    // Choose the first address and the enables for the current form.
    always_comb begin
        unique case (mode)
            AM_INDEX:              nx_addr0 = idx_addr;
            AM_PREINC, AM_POSTINC: nx_addr0 = inc_addr;
            default:               nx_addr0 = pr_addr0;
        endcase
        nx_wb_en = ((mode == AM_PREINC) || (mode == AM_POSTINC)) && !bad;
        nx_a1_en = (mode == AM_PAIR) && !bad;
    end

    // Register results; flags only follow a live request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            addr0     <= '0;
            addr1     <= '0;
            wb_value  <= '0;
            wb_en     <= 1'b0;
            addr1_en  <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            wb_en     <= req_valid && nx_wb_en;
            addr1_en  <= req_valid && nx_a1_en;
            illegal   <= req_valid && bad;
            if (req_valid) begin
                addr0    <= nx_addr0;
                addr1    <= pr_addr1;
                wb_value <= inc_wb;
            end
        end
    end

    // R1: results follow the request by one clock.
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !wb_en && !addr1_en && !illegal));
    // R5: in the update-before form, the access uses the updated base.
    a_r5_pre_match: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_mode == 2'd1) |=> (addr0 == wb_value));
    // R6: in the update-after form, the access uses the old base.
    a_r6_post_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_mode == 2'd2) |=> (addr0 == $past(base)));
    // R7: an increment load onto its own base register is rejected.
    a_r7_inc_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_mode[1] != op_mode[0] && is_load && rs1 == rd) |=> (illegal && !wb_en));
    // R8: the second pair address lies one element above the first.
    a_r8_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
        addr1_en |-> ((addr1 - addr0 == XLEN'(8)) || (addr1 - addr0 == XLEN'(4))));
    // R9: a flagged request enables nothing.
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && !addr1_en));
    // R10: writeback and the second address never appear together.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && addr1_en));
endmodule

// File: tb/agen_top_tb.sv
module agen_top_tb;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      op_mode = '0;
    logic            is_load = 1'b0, idx_zext = 1'b0, pair_dw = 1'b0;
    logic [XLEN-1:0] base = '0, index = '0;
    logic [4:0]      imm5 = '0;
    logic [1:0]      scale = '0, sh2 = '0;
    logic [4:0]      rs1 = '0, rd = '0, rd2 = '0;
    logic            out_valid, addr1_en, wb_en, illegal;
    logic [XLEN-1:0] addr0, addr1, wb_value;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    agen_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_mode(op_mode),
        .is_load(is_load), .idx_zext(idx_zext), .pair_dw(pair_dw),
        .base(base), .index(index), .imm5(imm5), .scale(scale), .sh2(sh2),
        .rs1(rs1), .rd(rd), .rd2(rd2), .out_valid(out_valid), .addr0(addr0),
        .addr1(addr1), .addr1_en(addr1_en), .wb_value(wb_value), .wb_en(wb_en),
        .illegal(illegal)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        ld, zx, dw;
        logic [63:0] b, ix;
        logic [4:0]  im;
        logic [1:0]  sc, s2;
        logic [4:0]  r1, r0, r2;
        logic [63:0] a0, a1, wb;
        logic        a1en, wben, ill;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R2 indexed, positive index, scale 2
        '{2'd0,1'b0,1'b0,1'b0,64'h1000,64'h10,5'd0,2'd2,2'd0,5'd1,5'd2,5'd0,64'h1040,64'h0,64'h0,1'b0,1'b0,1'b0},
        // R2 indexed, index -1, scale 3
        '{2'd0,1'b1,1'b0,1'b0,64'h1000,64'hFFFF_FFFF_FFFF_FFFF,5'd0,2'd3,2'd0,5'd1,5'd2,5'd0,64'hFF8,64'h0,64'h0,1'b0,1'b0,1'b0},
        // R3 zero-extended low word, scale 3
        '{2'd0,1'b1,1'b1,1'b0,64'h1000,64'hFFFF_FFFF_FFFF_FFFF,5'd0,2'd3,2'd0,5'd1,5'd2,5'd0,64'h8_0000_0FF8,64'h0,64'h0,1'b0,1'b0,1'b0},
        // R3 high bits discarded
        '{2'd0,1'b1,1'b1,1'b0,64'h1000,64'hABCD_0000_0000_0002,5'd0,2'd0,2'd0,5'd1,5'd2,5'd0,64'h1002,64'h0,64'h0,1'b0,1'b0,1'b0},
        // R5 R4 update-before, +3<<2
        '{2'd1,1'b1,1'b0,1'b0,64'h2000,64'h0,5'b00011,2'd2,2'd0,5'd2,5'd3,5'd0,64'h200C,64'h0,64'h200C,1'b0,1'b1,1'b0},
        // R6 R4 update-after, -2<<3
        '{2'd2,1'b1,1'b0,1'b0,64'h2000,64'h0,5'b11110,2'd3,2'd0,5'd2,5'd3,5'd0,64'h2000,64'h0,64'h1FF0,1'b0,1'b1,1'b0},
        // R7 R4 store with rs1==rd is legal, -16
        '{2'd1,1'b0,1'b0,1'b0,64'h2000,64'h0,5'b10000,2'd0,2'd0,5'd4,5'd4,5'd0,64'h1FF0,64'h0,64'h1FF0,1'b0,1'b1,1'b0},
        // R7 load with rs1==rd is illegal
        '{2'd2,1'b1,1'b0,1'b0,64'h2000,64'h0,5'd1,2'd0,2'd0,5'd5,5'd5,5'd0,64'h2000,64'h0,64'h0,1'b0,1'b0,1'b1},
        // R8 doubleword pair, sh2=3
        '{2'd3,1'b1,1'b0,1'b1,64'h3000,64'h0,5'd0,2'd0,2'd3,5'd1,5'd2,5'd3,64'h3030,64'h3038,64'h0,1'b1,1'b0,1'b0},
        // R8 word pair, sh2=2
        '{2'd3,1'b1,1'b0,1'b0,64'h3000,64'h0,5'd0,2'd0,2'd2,5'd1,5'd2,5'd3,64'h3010,64'h3014,64'h0,1'b1,1'b0,1'b0},
        // R9 load, rd==rd2
        '{2'd3,1'b1,1'b0,1'b1,64'h3000,64'h0,5'd0,2'd0,2'd0,5'd1,5'd4,5'd4,64'h3000,64'h0,64'h0,1'b0,1'b0,1'b1},
        // R9 load, rs1==rd2
        '{2'd3,1'b1,1'b0,1'b0,64'h3000,64'h0,5'd0,2'd0,2'd0,5'd6,5'd2,5'd6,64'h3000,64'h0,64'h0,1'b0,1'b0,1'b1},
        // R9 load, rs1==rd
        '{2'd3,1'b1,1'b0,1'b0,64'h3000,64'h0,5'd0,2'd0,2'd0,5'd7,5'd7,5'd8,64'h3000,64'h0,64'h0,1'b0,1'b0,1'b1},
        // R9 R10 store pair with rs1==rd stays legal
        '{2'd3,1'b0,1'b0,1'b0,64'h3000,64'h0,5'd0,2'd0,2'd0,5'd1,5'd1,5'd1,64'h3000,64'h3004,64'h0,1'b1,1'b0,1'b0}
    };

    function automatic string tag_of(input vec_t v);
        case (v.mode)
            2'd0: tag_of = v.zx ? "R3" : "R2";
            2'd1: tag_of = v.ill ? "R7" : "R5";
            2'd2: tag_of = v.ill ? "R7" : "R6";
            default: tag_of = v.ill ? "R9" : "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; op_mode = v.mode; is_load = v.ld; idx_zext = v.zx; pair_dw = v.dw;
        base = v.b; index = v.ix; imm5 = v.im; scale = v.sc; sh2 = v.s2;
        rs1 = v.r1; rd = v.r0; rd2 = v.r2;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk("R1", "flags after reset", {61'd0, wb_en, addr1_en, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle out_valid", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = tag_of(v);
            drive(v);
            chk("R1", "out_valid", 64'(out_valid), 64'd1);
            chk(t, "addr0", addr0, v.a0);
            chk(t, "illegal", 64'(illegal), 64'(v.ill));
            chk(v.mode == 2'd3 ? t : "R10", "addr1_en", 64'(addr1_en), 64'(v.a1en));
            chk(v.mode[0] ^ v.mode[1] ? t : "R10", "wb_en", 64'(wb_en), 64'(v.wben));
            if (v.a1en) chk(t, "addr1", addr1, v.a1);
            if (v.wben) chk(t, "wb_value", wb_value, v.wb);
            // R1 a cycle without a request clears valid and flags
            @(negedge clk);
            chk("R1", "no-request cycle", {60'd0, out_valid, wb_en, addr1_en, illegal}, 64'd0);
        end

        // R1 reset taken with a request in flight
        @(negedge clk);
        req_valid = 1'b1; op_mode = 2'd1; is_load = 1'b0; imm5 = 5'd1; scale = 2'd0; rs1 = 5'd1; rd = 5'd2;
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b1;
        chk("R1", "reset over request valid", 64'(out_valid), 64'd0);
        chk("R1", "reset over request wb_en", 64'(wb_en), 64'd0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule